// File: doc/BRIEF.md
# SAR Conversion Sequencer with Parallel Result Bus

This block is the digital controller of a four-input successive-approximation converter. A host starts a conversion with an active-low write strobe while the chip select is low. The block then works through the result one bit per conversion clock, most significant bit first. On each cycle it reads a single comparator bit, which tells it whether the analog input is at or above the current trial code.

A busy flag is low while the conversion runs. When the flag goes high again, the result can be read from a parallel bus. The bus is only enabled while chip select and the read strobe are both low. The channel address is captured on write or read strobe release and is used by the following conversion. The host can put the block to sleep by releasing the read strobe with address bit 0 high, and wake it by doing the same with bit 0 low.

All strobes are sampled on the conversion clock. An edge is recognised when the sampled level differs from the level seen on the previous clock.

Top module: `sar_seq`

## Requirements
- R1: After reset `busy_n` is 1, `data_oe` is 0, `data_out` is 0 and `chan_sel` is 0.
- R2: Conversion start: `wr_n` is seen going low with `cs_n` low while the block is idle. `busy_n` then goes low after that same clock edge.
- R3: The block decides one bit per clock, starting from trial code 100000000000b. In the cycle for bit i, the trial bit i is kept when `cmp_in` is 1 and cleared when it is 0. After a start, `busy_n` stays low for exactly 12 clocks.
- R4: On the edge that decides bit 0, `data_out` takes the final code and `busy_n` returns to 1. The code is straight binary. `data_out` does not change while `busy_n` is low.
- R5: `addr` is captured when `wr_n` or `rd_n` rises while `cs_n` is low. The captured value drives `chan_sel` from the start of the next conversion, with `chan_sel` equal to the address value (0 to 3 select inputs 0 to 3).
- R6: `data_oe` is 1 only while `cs_n` and `rd_n` are both low, `busy_n` is 1 and the block is awake.
- R7: While idle, a rise of `rd_n` with `cs_n` low and `addr[0]`=1 puts the block to sleep. While asleep, write strobes start nothing, `busy_n` stays 1 and `data_oe` stays 0.
- R8: While asleep, a rise of `rd_n` with `cs_n` low and `addr[0]`=0 returns the block to idle, and conversions work again.
- R9: A write strobe during a conversion neither aborts nor restarts it. The result and the channel in use are unchanged.
- R10: An input that is below every trial code yields 000h. An input that is at or above every trial code yields FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe (start, address capture) |
| rd_n | input | 1 | Active-low read strobe (bus enable, address capture, sleep control) |
| addr | input | 2 | Channel address |
| cmp_in | input | 1 | Comparator result: 1 when input is at or above the trial code |
| busy_n | output | 1 | Low while a conversion runs |
| data_out | output | 12 | Conversion result |
| data_oe | output | 1 | Output enable for the result bus |
| chan_sel | output | 2 | Multiplexer channel used by the current conversion |

## Verification
The bench builds the block with its defaults: 12 result bits and a 2-bit channel address. At these values every channel code can be reached, as can both extreme codes 000h and FFFh. The bench runs the full 12-step bit-decision walk on codes chosen so that each bit position is kept and cleared at least once. It also covers the one-conversion lag of the address pipeline, a write strobe that arrives mid-conversion, and a sleep and wake round trip.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [CHAN_W-1:0] addr,
  input  logic              cmp_in,
  output logic              busy_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic [CHAN_W-1:0] chan_sel
);
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_SLEEP} st_t;

  st_t               state;
  logic              wr_q, rd_q;
  logic [CHAN_W-1:0] addr_q;
  logic [DATA_W-1:0] sar, trial;
  logic              asleep;
  logic              wr_fall, wr_rise, rd_rise;
  logic [DATA_W-1:0] keep;

  assign wr_fall = wr_q & ~wr_n & ~cs_n;
  assign wr_rise = ~wr_q & wr_n & ~cs_n;
  assign rd_rise = ~rd_q & rd_n & ~cs_n;
  assign keep    = cmp_in ? sar : (sar & ~trial);
  assign asleep  = (state == S_SLEEP);
  assign busy_n  = (state != S_CONV);
  assign data_oe = ~cs_n & ~rd_n & busy_n & ~asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wr_q     <= 1'b1;
      rd_q     <= 1'b1;
      addr_q   <= '0;
      chan_sel <= '0;
      sar      <= '0;
      trial    <= '0;
      data_out <= '0;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
      if (wr_rise || rd_rise) addr_q <= addr;
      case (state)
        S_IDLE: begin
          if (wr_fall) begin
            state    <= S_CONV;
            sar      <= TOP_BIT;
            trial    <= TOP_BIT;
            chan_sel <= addr_q;
          end else if (rd_rise && addr[0]) begin
            state <= S_SLEEP;
          end
        end
        S_CONV: begin
          sar   <= keep | (trial >> 1);
          trial <= trial >> 1;
          if (trial[0]) begin
            data_out <= keep;
            state    <= S_IDLE;
          end
        end
        S_SLEEP: begin
          if (rd_rise && !addr[0]) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wr_n,
  input logic              busy_n,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out,
  input logic [CHAN_W-1:0] chan_sel,
  input logic              asleep
);
  localparam int CW = $clog2(DATA_W + 1) + 1;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!busy_n) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(!wr_n && !cs_n));

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> (low_cnt < CW'(DATA_W)));

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> $stable(data_out));

  // R9
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && $past(!busy_n)) |-> $stable(chan_sel));

  // R7
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> busy_n);

  // R6
  oe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && $past(data_oe)) |-> $stable(data_out));
endmodule

bind sar_seq sar_seq_chk #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .busy_n(busy_n),
  .data_oe(data_oe), .data_out(data_out), .chan_sel(chan_sel), .asleep(asleep)
);

// File: tb/sar_seq_test.sv
module sar_seq_test;
  localparam int DW = 12;
  localparam int NV = 6;
  localparam logic [11:0] CODES [NV] = '{12'hA5C, 12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'h3A1};
  localparam logic [1:0]  NEXTA [NV] = '{2'd1, 2'd3, 2'd2, 2'd0, 2'd2, 2'd1};

  logic clk = 0, rst_n = 0, cs_n = 1, wr_n = 1, rd_n = 1, cmp_in = 0;
  logic [1:0] addr = 0;
  logic busy_n, data_oe;
  logic [DW-1:0] data_out;
  logic [1:0] chan_sel;
  int total = 0, bad = 0;
  logic [1:0] exp_ch;

  sar_seq uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .cmp_in(cmp_in), .busy_n(busy_n), .data_out(data_out),
    .data_oe(data_oe), .chan_sel(chan_sel));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [11:0] code, input logic [1:0] nxt,
                         input logic [1:0] ch, input bit midwr);
    logic [11:0] acc = 0;
    logic [11:0] tr;
    int lowc = 0;
    @(negedge clk); cs_n = 0; wr_n = 0; addr = nxt;
    @(negedge clk); wr_n = 1;
    chk("R2 busy low after start", busy_n, 0);
    chk("R5 chan_sel", chan_sel, ch);
    for (int i = DW-1; i >= 0; i--) begin
      tr = acc | (12'd1 << i);
      cmp_in = (code >= tr);
      if (midwr && i == 6) wr_n = 0;
      if (midwr && i == 5) wr_n = 1;
      @(negedge clk);
      if (cmp_in) acc = tr;
      if (!busy_n) lowc++;
      if (i == 6) chk("R6 oe off while busy", data_oe, 0);
    end
    cmp_in = 0;
    chk("R3 busy low count", lowc, DW-1);
    chk("R4 busy high after lsb", busy_n, 1);
    chk("R3 R4 R10 result", data_out, code);
    if (midwr) chk("R9 chan unchanged", chan_sel, ch);
    cs_n = 1;
    @(negedge clk); rd_n = 0;
    #1 chk("R6 oe off with cs high", data_oe, 0);
    @(negedge clk); cs_n = 0;
    #1 chk("R6 oe on when read", data_oe, 1);
    chk("R4 bus value", data_out, code);
    @(negedge clk); cs_n = 1;
    @(negedge clk); rd_n = 1;
  endtask

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy_n", busy_n, 1);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 data_out", data_out, 0);
    chk("R1 chan_sel", chan_sel, 0);
    rst_n = 1;
    exp_ch = 0;
    for (int v = 0; v < NV; v++) begin
      convert(CODES[v], NEXTA[v], exp_ch, 0);
      exp_ch = NEXTA[v];
    end
    // R9: write strobe during conversion, address 3 latched on its rise
    convert(12'h5B6, 2'd3, exp_ch, 1);
    exp_ch = 3;
    // R7: enter sleep with A0 high
    @(negedge clk); cs_n = 0; rd_n = 0; addr = 2'd1;
    @(negedge clk); rd_n = 1;
    @(negedge clk); wr_n = 0;
    @(negedge clk); wr_n = 1;
    repeat (3) @(negedge clk);
    chk("R7 write ignored asleep", busy_n, 1);
    rd_n = 0;
    #1 chk("R7 oe off asleep", data_oe, 0);
    // R8: wake with A0 low, address 2 latched on rd rise
    addr = 2'd2;
    @(negedge clk); rd_n = 1;
    @(negedge clk); cs_n = 1;
    convert(12'h0F0, 2'd0, 2'd2, 0);
    chk("R8 R5 awake chan", chan_sel, 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule